// File: doc/BRIEF.md
# Burst Memory User Port

This block is the user-facing side of a memory port. Client logic works with three queues. The first is a command queue, where each entry carries an operation code, a byte address and a burst length. The second is a write-data queue of 32-bit words, each with a per-byte mask. The third is a read-data queue that returns 32-bit words. An executor takes commands off the command queue one at a time and carries out the burst. It moves words from the write queue into a small word-addressed storage array, or from that array into the read queue.

The storage array stands in for the external memory and its controller, so the port can be exercised on its own. Each queue exposes empty and full flags. The read queue also exposes its occupancy. Two sticky error flags report misuse. One is set by a write burst that asks for more words than are waiting. The other is set by read data that arrives while the read queue is full.

Top module: `mport_user_port`

## Requirements
- R1: After reset, cmd_empty, wr_empty and rd_empty are 1, cmd_full, wr_full and rd_full are 0, rd_count is 0, and both error flags are 0.
- R2: Opcode 3'b000 (write) pops burst words from the write queue and stores them at consecutive word addresses. Opcode 3'b001 (read) pushes the stored words from consecutive word addresses into the read queue, in address order.
- R3: The cmd_bl field encodes the burst as word count minus one, so a value of n moves n+1 words. The range is 1 to 64 words.
- R4: For bit i of wr_mask, a 1 leaves byte i (data bits 8i+7..8i) of the target word unchanged, and a 0 writes that byte.
- R5: The two least significant bits of cmd_addr are ignored. The word address is cmd_addr shifted right by two.
- R6: A command with any opcode other than write or read is removed from the command queue. It changes no stored word, consumes no write word and produces no read word.
- R7: The command queue holds 4 entries. cmd_full is 1 while 4 entries wait, and cmd_empty is 1 while none wait.
- R8: The read queue holds 64 words. rd_count gives the number of waiting words, and rd_full is 1 exactly when 64 words wait.
- R9: A read word produced while the read queue is full is dropped and sets rd_overflow. rd_overflow then stays 1 until reset.
- R10: A write command whose burst exceeds the number of words in the write queue is discarded without consuming any words, and it sets wr_underrun. wr_underrun stays 1 until reset.
- R11: The write queue holds 64 words. wr_full is 1 exactly when 64 words wait, and a 64-word write burst drains it completely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_push | input | 1 | Enqueue a command (ignored when full) |
| cmd_op | input | 3 | Operation code: 000 write, 001 read |
| cmd_addr | input | 8 | Starting byte address |
| cmd_bl | input | 6 | Burst length minus one |
| cmd_full | output | 1 | Command queue full |
| cmd_empty | output | 1 | Command queue empty |
| wr_push | input | 1 | Enqueue a write word (ignored when full) |
| wr_data | input | 32 | Write word |
| wr_mask | input | 4 | Per-byte keep mask, 1 = byte unchanged |
| wr_full | output | 1 | Write queue full |
| wr_empty | output | 1 | Write queue empty |
| rd_pop | input | 1 | Dequeue the head read word (ignored when empty) |
| rd_data | output | 32 | Head read word, valid while rd_empty is 0 |
| rd_full | output | 1 | Read queue full |
| rd_empty | output | 1 | Read queue empty |
| rd_count | output | 7 | Read queue occupancy |
| wr_underrun | output | 1 | Sticky write underrun error |
| rd_overflow | output | 1 | Sticky read overflow error |

## Verification
A wrong executor address or burst counter shows up as a wrong word or a missing word in the read stream. The scoreboard catches it at the first mismatched pop, a few cycles after the read command. A queue pointer or count error shows up within one cycle as a wrong flag or a wrong rd_count at the fill and drain points. Mis-handled masks or dropped opcode checks corrupt a stored word, and the next read of that address exposes it. A flag that is not sticky is caught the next time it is sampled after its cause has passed.

// File: rtl/mport_pkg.sv
package mport_pkg;
    localparam int ADDR_W = 8;
    localparam int BL_W   = 6;
    localparam int WORD_W = 32;
    localparam int MASK_W = WORD_W / 8;
    localparam int OP_W   = 3;

    localparam logic [OP_W-1:0] OP_WRITE = 3'b000;
    localparam logic [OP_W-1:0] OP_READ  = 3'b001;

    typedef enum logic [1:0] {
        EX_IDLE,
        EX_WRITE,
        EX_READ
    } ex_state_e;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [ADDR_W-1:0] addr;
        logic [BL_W-1:0]   bl;
    } cmd_t;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic [WORD_W-1:0] data;
    } wword_t;
endpackage

// File: rtl/mport_fifo.sv
module mport_fifo #(
    parameter  int W     = 32,
    parameter  int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fifo_state_t;

    fifo_state_t s_d, s_q;
    logic [W-1:0] store_q [DEPTH];
    logic         push_ok, pop_ok;

    always_comb begin
        push_ok = push && (s_q.cnt != CNT_W'(DEPTH));
        pop_ok  = pop && (s_q.cnt != '0);
        s_d     = s_q;
        if (push_ok) s_d.wp = s_q.wp + 1'b1;
        if (pop_ok)  s_d.rp = s_q.rp + 1'b1;
        s_d.cnt = s_q.cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) store_q[s_q.wp] <= din;
    end

    assign dout  = store_q[s_q.rp];
    assign full  = (s_q.cnt == CNT_W'(DEPTH));
    assign empty = (s_q.cnt == '0);
    assign count = s_q.cnt;
endmodule

// File: rtl/mport_exec.sv
module mport_exec
    import mport_pkg::*;
#(
    parameter  int WCNT_W    = 7,
    localparam int MEM_WORDS = 2 ** (ADDR_W - 2),
    localparam int IDX_W     = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_empty,
    input  cmd_t              cmd_head,
    output logic              cmd_pop,
    input  logic [WCNT_W-1:0] wr_count,
    input  wword_t            wr_head,
    output logic              wr_pop,
    input  logic              rd_full,
    output logic              rd_push,
    output logic [WORD_W-1:0] rd_word,
    output logic              wr_underrun,
    output logic              rd_overflow
);
    typedef struct packed {
        ex_state_e       st;
        logic [IDX_W-1:0] idx;
        logic [BL_W-1:0]  remain;
        logic             ur;
        logic             ov;
    } ex_t;

    ex_t s_d, s_q;
    logic [WORD_W-1:0] mem_q [MEM_WORDS];
    logic              mem_we;

    always_comb begin
        s_d     = s_q;
        cmd_pop = 1'b0;
        wr_pop  = 1'b0;
        rd_push = 1'b0;
        mem_we  = 1'b0;
        rd_word = mem_q[s_q.idx];
        unique case (s_q.st)
            EX_IDLE: begin
                if (!cmd_empty) begin
                    cmd_pop = 1'b1;
                    if (cmd_head.op == OP_WRITE) begin
                        if (int'(wr_count) <= int'(cmd_head.bl)) begin
                            s_d.ur = 1'b1;
                        end else begin
                            s_d.st     = EX_WRITE;
                            s_d.idx    = cmd_head.addr[ADDR_W-1:2];
                            s_d.remain = cmd_head.bl;
                        end
                    end else if (cmd_head.op == OP_READ) begin
                        s_d.st     = EX_READ;
                        s_d.idx    = cmd_head.addr[ADDR_W-1:2];
                        s_d.remain = cmd_head.bl;
                    end
                end
            end
            EX_WRITE: begin
                wr_pop     = 1'b1;
                mem_we     = 1'b1;
                s_d.idx    = s_q.idx + 1'b1;
                s_d.remain = s_q.remain - 1'b1;
                if (s_q.remain == '0) s_d.st = EX_IDLE;
            end
            EX_READ: begin
                if (rd_full) s_d.ov = 1'b1;
                else         rd_push = 1'b1;
                s_d.idx    = s_q.idx + 1'b1;
                s_d.remain = s_q.remain - 1'b1;
                if (s_q.remain == '0) s_d.st = EX_IDLE;
            end
            default: s_d.st = EX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: EX_IDLE, idx: '0, remain: '0, ur: 1'b0, ov: 1'b0};
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (mem_we) begin
            for (int b = 0; b < MASK_W; b++) begin
                if (!wr_head.mask[b]) mem_q[s_q.idx][8*b +: 8] <= wr_head.data[8*b +: 8];
            end
        end
    end

    assign wr_underrun = s_q.ur;
    assign rd_overflow = s_q.ov;
endmodule

// File: rtl/mport_user_port.sv
module mport_user_port
    import mport_pkg::*;
#(
    parameter  int CMD_DEPTH  = 4,
    parameter  int DATA_DEPTH = 64,
    localparam int DCNT_W     = $clog2(DATA_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_push,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [BL_W-1:0]   cmd_bl,
    output logic              cmd_full,
    output logic              cmd_empty,
    input  logic              wr_push,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [MASK_W-1:0] wr_mask,
    output logic              wr_full,
    output logic              wr_empty,
    input  logic              rd_pop,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_full,
    output logic              rd_empty,
    output logic [DCNT_W-1:0] rd_count,
    output logic              wr_underrun,
    output logic              rd_overflow
);
    localparam int CCNT_W = $clog2(CMD_DEPTH + 1);

    cmd_t              cmd_in, cmd_head;
    wword_t            wr_in, wr_head;
    logic              cmd_pop, wr_pop, rd_push;
    logic [WORD_W-1:0] rd_word;
    logic [CCNT_W-1:0] cmd_cnt;
    logic [DCNT_W-1:0] wr_cnt;

    assign cmd_in = '{op: cmd_op, addr: cmd_addr, bl: cmd_bl};
    assign wr_in  = '{mask: wr_mask, data: wr_data};

    mport_fifo #(.W($bits(cmd_t)), .DEPTH(CMD_DEPTH)) i_cmd_q (
        .clk(clk), .rst_n(rst_n), .push(cmd_push), .din(cmd_in), .pop(cmd_pop),
        .dout(cmd_head), .full(cmd_full), .empty(cmd_empty), .count(cmd_cnt)
    );

    mport_fifo #(.W($bits(wword_t)), .DEPTH(DATA_DEPTH)) i_wr_q (
        .clk(clk), .rst_n(rst_n), .push(wr_push), .din(wr_in), .pop(wr_pop),
        .dout(wr_head), .full(wr_full), .empty(wr_empty), .count(wr_cnt)
    );

    mport_fifo #(.W(WORD_W), .DEPTH(DATA_DEPTH)) i_rd_q (
        .clk(clk), .rst_n(rst_n), .push(rd_push), .din(rd_word), .pop(rd_pop),
        .dout(rd_data), .full(rd_full), .empty(rd_empty), .count(rd_count)
    );

    mport_exec #(.WCNT_W(DCNT_W)) i_exec (
        .clk(clk), .rst_n(rst_n),
        .cmd_empty(cmd_empty), .cmd_head(cmd_head), .cmd_pop(cmd_pop),
        .wr_count(wr_cnt), .wr_head(wr_head), .wr_pop(wr_pop),
        .rd_full(rd_full), .rd_push(rd_push), .rd_word(rd_word),
        .wr_underrun(wr_underrun), .rd_overflow(rd_overflow)
    );

    logic unused_cnt;
    assign unused_cnt = ^cmd_cnt;
endmodule

// File: rtl/mport_user_port_chk.sv
module mport_user_port_chk #(
    parameter int DATA_DEPTH = 64,
    parameter int CNT_W      = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_full,
    input logic             cmd_empty,
    input logic             wr_full,
    input logic             wr_empty,
    input logic             rd_full,
    input logic             rd_empty,
    input logic [CNT_W-1:0] rd_count,
    input logic             wr_underrun,
    input logic             rd_overflow
);
    assert_cmd_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_full |-> !cmd_empty);

    assert_wr_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_full |-> !wr_empty);

    assert_rd_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_count == $past(rd_count)) || (rd_count == $past(rd_count) + 1'b1) ||
        (rd_count + 1'b1 == $past(rd_count)));

    assert_rd_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rd_count) <= DATA_DEPTH);

    assert_ov_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_overflow) |-> $past(rd_full));

    assert_ov_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_overflow) |-> rd_overflow);

    assert_ur_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_underrun) |-> wr_underrun);
endmodule

bind mport_user_port mport_user_port_chk #(.DATA_DEPTH(DATA_DEPTH), .CNT_W(DCNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .cmd_full(cmd_full), .cmd_empty(cmd_empty),
    .wr_full(wr_full), .wr_empty(wr_empty), .rd_full(rd_full), .rd_empty(rd_empty),
    .rd_count(rd_count), .wr_underrun(wr_underrun), .rd_overflow(rd_overflow)
);

// File: tb/test_mport_user_port.sv
module test_mport_user_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_push = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [7:0]  cmd_addr = '0;
    logic [5:0]  cmd_bl = '0;
    logic        cmd_full, cmd_empty;
    logic        wr_push = 1'b0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_mask = '0;
    logic        wr_full, wr_empty;
    logic        rd_pop = 1'b0;
    logic [31:0] rd_data;
    logic        rd_full, rd_empty;
    logic [6:0]  rd_count;
    logic        wr_underrun, rd_overflow;

    int          total = 0;
    int          bad = 0;
    bit          mon_en = 1'b0;
    logic [31:0] model [64];
    logic [31:0] expq [$];
    logic [31:0] pend_data [$];
    logic [3:0]  pend_mask [$];

    always #5 clk = ~clk;

    mport_user_port i_mport_user_port (
        .clk(clk), .rst_n(rst_n), .cmd_push(cmd_push), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_bl(cmd_bl), .cmd_full(cmd_full), .cmd_empty(cmd_empty), .wr_push(wr_push),
        .wr_data(wr_data), .wr_mask(wr_mask), .wr_full(wr_full), .wr_empty(wr_empty),
        .rd_pop(rd_pop), .rd_data(rd_data), .rd_full(rd_full), .rd_empty(rd_empty),
        .rd_count(rd_count), .wr_underrun(wr_underrun), .rd_overflow(rd_overflow)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_word(input logic [31:0] d, input logic [3:0] m);
        wr_push = 1'b1; wr_data = d; wr_mask = m;
        pend_data.push_back(d); pend_mask.push_back(m);
        @(negedge clk);
        wr_push = 1'b0;
    endtask

    task automatic push_cmd(input logic [2:0] op, input logic [7:0] a, input logic [5:0] bl);
        cmd_push = 1'b1; cmd_op = op; cmd_addr = a; cmd_bl = bl;
        @(negedge clk);
        cmd_push = 1'b0;
    endtask

    // write command: the model consumes pending words at issue
    task automatic do_write(input logic [7:0] a, input logic [5:0] bl);
        for (int i = 0; i <= int'(bl); i++) begin
            logic [31:0] d;
            logic [3:0]  m;
            int          w;
            d = pend_data.pop_front();
            m = pend_mask.pop_front();
            w = (int'(a >> 2) + i) % 64;
            for (int b = 0; b < 4; b++) if (!m[b]) model[w][8*b +: 8] = d[8*b +: 8];
        end
        push_cmd(3'b000, a, bl);
    endtask

    // read command with expectations for the scoreboard
    task automatic do_read(input logic [7:0] a, input logic [5:0] bl);
        for (int i = 0; i <= int'(bl); i++) expq.push_back(model[(int'(a >> 2) + i) % 64]);
        push_cmd(3'b001, a, bl);
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // monitor: pops the read queue and compares against the scoreboard (R2, R3)
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && !rd_empty) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R2 unexpected read word", rd_data, 32'h0);
                end else begin
                    logic [31:0] e;
                    e = expq.pop_front();
                    check(rd_data === e, "R2 read data", rd_data, e);
                end
                rd_pop = 1'b1;
            end else begin
                rd_pop = 1'b0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 32'h0, 32'h1);
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(cmd_empty && wr_empty && rd_empty, "R1 empties", {cmd_empty, wr_empty, rd_empty}, 3'b111);
        check(!cmd_full && !wr_full && !rd_full, "R1 fulls", {cmd_full, wr_full, rd_full}, 3'b000);
        check(rd_count == 0 && !wr_underrun && !rd_overflow, "R1 count/errors",
              {rd_count, wr_underrun, rd_overflow}, 32'h0);

        // R11: fill write queue, one 64-word burst fills the whole store
        for (int i = 0; i < 64; i++) push_word(32'hA500_0000 + i * 32'h0101_0003, 4'b0000);
        check(wr_full === 1'b1, "R11 wr_full at 64", wr_full, 1'b1);
        do_write(8'h00, 6'd63);
        repeat (70) @(negedge clk);
        check(wr_empty && !wr_full, "R11 drained", {wr_empty, wr_full}, 2'b10);

        mon_en = 1'b1;
        // R2, R3: 4-word read from word 2
        do_read(8'h08, 6'd3);
        repeat (10) @(negedge clk);
        check(expq.size() == 0, "R3 four words returned", expq.size(), 0);

        // R4: byte mask
        push_word(32'h1122_3344, 4'b0101);
        do_write(8'h10, 6'd0);
        repeat (5) @(negedge clk);
        do_read(8'h10, 6'd0);
        repeat (6) @(negedge clk);
        check(expq.size() == 0, "R4 masked word read", expq.size(), 0);

        // R5: low address bits ignored
        push_word(32'hDEAD_BEEF, 4'b0000);
        push_word(32'h0BAD_CAFE, 4'b0000);
        do_write(8'h23, 6'd1);
        repeat (6) @(negedge clk);
        do_read(8'h21, 6'd1);
        repeat (8) @(negedge clk);
        check(expq.size() == 0, "R5 unaligned read", expq.size(), 0);

        // R6: unknown opcode is discarded
        push_word(32'h5555_AAAA, 4'b0000);
        push_cmd(3'b101, 8'h00, 6'd0);
        repeat (5) @(negedge clk);
        check(cmd_empty && !wr_empty && rd_empty, "R6 nothing consumed/produced",
              {cmd_empty, wr_empty, rd_empty}, 3'b101);
        do_read(8'h00, 6'd0);
        repeat (6) @(negedge clk);
        check(expq.size() == 0, "R6 store unchanged", expq.size(), 0);
        do_write(8'h30, 6'd0);
        repeat (5) @(negedge clk);

        // R10: underrun
        push_word(32'h1234_5678, 4'b0000);
        push_word(32'h9ABC_DEF0, 4'b0000);
        push_cmd(3'b000, 8'h40, 6'd2);
        repeat (5) @(negedge clk);
        check(wr_underrun === 1'b1, "R10 underrun set", wr_underrun, 1'b1);
        check(!wr_empty && cmd_empty, "R10 words kept", {wr_empty, cmd_empty}, 2'b01);
        do_read(8'h40, 6'd0);
        repeat (6) @(negedge clk);
        check(expq.size() == 0, "R10 store unchanged", expq.size(), 0);
        do_write(8'h40, 6'd1);
        repeat (6) @(negedge clk);
        do_read(8'h40, 6'd1);
        repeat (8) @(negedge clk);

        // R7, R8, R9: fill command and read queues
        mon_en = 1'b0;
        repeat (2) @(negedge clk);
        push_cmd(3'b001, 8'h00, 6'd63);
        for (int i = 0; i < 4; i++) push_cmd(3'b111, 8'h00, 6'd0);
        check(cmd_full && !cmd_empty, "R7 cmd_full at 4", {cmd_full, cmd_empty}, 2'b10);
        repeat (80) @(negedge clk);
        check(rd_full === 1'b1 && rd_count == 7'd64, "R8 rd full count", rd_count, 32'd64);
        check(rd_overflow === 1'b0, "R9 no overflow yet", rd_overflow, 1'b0);
        push_cmd(3'b001, 8'h04, 6'd0);
        repeat (5) @(negedge clk);
        check(rd_overflow === 1'b1, "R9 overflow set", rd_overflow, 1'b1);
        for (int i = 0; i < 64; i++) expq.push_back(model[i]);
        mon_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(rd_count == 7'd63, "R8 count after one pop", rd_count, 32'd63);
        repeat (80) @(negedge clk);
        check(rd_empty && rd_count == 0, "R8 drained", rd_count, 32'd0);
        check(expq.size() == 0, "R9 dropped word absent", expq.size(), 0);
        check(rd_overflow === 1'b1, "R9 sticky", rd_overflow, 1'b1);
        check(wr_underrun === 1'b1, "R10 sticky", wr_underrun, 1'b1);
        check(cmd_empty === 1'b1, "R7 cmd drained", cmd_empty, 1'b1);
        finish_up();
    end
endmodule